// File: doc/BRIEF.md
# Programmable Compare/Overflow Timer

A 16-bit up-counter with three memory-mapped registers: count, control/status (mode) and compare. While running, the counter advances by one on each prescaled tick. A two-bit field in the mode register picks the prescale ratio applied to the bus clock. Two events can occur. A compare match happens when the count reaches or passes a nonzero, armed compare value. An overflow happens when the count wraps from 0xFFFF to zero. Each event, when its interrupt enable is set, latches a sticky status flag and raises a single-cycle pulse on the interrupt line.

Software may load the count or the compare value at any moment. A compare value written at or below the current count is held back until the counter has wrapped, so a late update never fires at once. Writing the count re-arms the comparator. A match can optionally zero the count, but only when the compare interrupt is enabled. Without that reset, a match disarms the comparator until the next wrap. The status flags are cleared only by writing one to them.

Top module: `tmr16_top`

## Requirements
- R1: After reset the count, mode and compare registers read zero and the interrupt line is low.
- R2: With mode bit 7 set the count rises by one per tick; with it clear the count holds and no event occurs.
- R3: Mode bits 1:0 select the tick period as 16^sel bus clocks (1, 16, 256, 4096); the prescaler restarts whenever counting is disabled.
- R4: A write to the count register (offset 0x0) loads bits 15:0 of the write data and re-arms a comparator that was deferred or disarmed.
- R5: When an armed, nonzero compare value is reached or passed, the comparator disarms; if mode bit 8 is set, the sticky compare flag (mode bit 10) is set and an interrupt is raised.
- R6: Mode bit 6 zeroes the count on a compare match only when mode bit 8 is also set; otherwise the count continues upward.
- R7: A compare value of zero never produces a compare match.
- R8: A tick at count 0xFFFF wraps the count to zero and re-arms the comparator; the sticky overflow flag (mode bit 11) and an interrupt are raised only if mode bit 9 is set.
- R9: A nonzero compare value written (offset 0x8) at or below the current count does not match until after the next wrap.
- R10: A mode write (offset 0x4) loads mode bits 9:0 from write data bits 9:0 and clears only those flags among bits 11:10 that are written as one; a flag being set in the same cycle wins.
- R11: The interrupt output is a one-cycle pulse in the cycle after any tick that raises an event; a tick raising both compare and overflow sets both flags and issues a single pulse.
- R12: Reads return count at 0x0, {flags, mode bits 9:0} at 0x4 and compare at 0x8, zero-extended; any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register offset for reads and writes |
| wr_en_i | input | 1 | Write strobe, one register write per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The bench writes compare values equal to and below the count. A comparator that fires on the next tick there, instead of after a wrap, sets the flag early. It also runs a deferred compare across a real wrap, and a design that never re-arms leaves the flag clear. Reset-on-match is tried with and without the compare interrupt enable. A design that ignores the dependency zeroes the count when it should not. A count at 0xFFFF is pushed into a compare and an overflow on the same tick, which catches a lost flag or a double pulse. Flag clearing, a zero compare value and the 1/16/256 prescale ratios are checked through register reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] OFS_CNT  = 4'h0;
  localparam logic [3:0] OFS_MODE = 4'h4;
  localparam logic [3:0] OFS_CMP  = 4'h8;

  localparam int unsigned CTL_W = 10;
  localparam int unsigned B_RST = 6;
  localparam int unsigned B_RUN = 7;
  localparam int unsigned B_CIE = 8;
  localparam int unsigned B_OIE = 9;
  localparam int unsigned B_CF  = 10;
  localparam int unsigned B_OF  = 11;

  typedef struct packed {
    logic ovf;
    logic cmp;
  } evt_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_STEP = 4,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned NSEL  = 1 << SEL_W;
  localparam int unsigned PRE_W = DIV_STEP * (NSEL - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask_tbl [NSEL];
  logic [PRE_W-1:0] mask;

  for (genvar g = 0; g < NSEL; g++) begin : g_mask
    assign mask_tbl[g] = PRE_W'((64'd1 << (g * DIV_STEP)) - 64'd1);
  end

  assign mask   = mask_tbl[sel_i];
  assign tick_o = run_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (run_i) pre_q <= pre_q + PRE_W'(1);
    else            pre_q <= '0;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] wval_i,
  input  logic             rst_on_cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cmp_o,
  output tmr_pkg::evt_t    evt_o
);
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             armed_q;
  logic [CNT_W:0]   nxt;
  logic             cmp_hit, ovf_hit, late_cmp;

  assign nxt     = {1'b0, cnt_q} + (CNT_W + 1)'(1);
  assign ovf_hit = tick_i && (&cnt_q);
  // compare against the unwrapped next value so a wrap tick can also match
  assign cmp_hit = tick_i && armed_q && (|cmp_q) && (nxt >= {1'b0, cmp_q});
  assign late_cmp = (|wval_i) && (wval_i <= cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_wr_i) begin
      cnt_q <= wval_i;
    end else if (tick_i) begin
      if (cmp_hit && rst_on_cmp_i) cnt_q <= '0;
      else                         cnt_q <= nxt[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= '0;
    else if (cmp_wr_i) cmp_q <= wval_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b1;
    else if (cnt_wr_i) armed_q <= 1'b1;
    else if (cmp_wr_i) armed_q <= !late_cmp;
    else if (ovf_hit)  armed_q <= 1'b1;
    else if (cmp_hit)  armed_q <= rst_on_cmp_i;
  end

  assign cnt_o     = cnt_q;
  assign cmp_o     = cmp_q;
  assign evt_o.cmp = cmp_hit;
  assign evt_o.ovf = ovf_hit;
endmodule

// File: rtl/tmr_csr.sv
module tmr_csr #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     mode_wr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [CNT_W-1:0]         cnt_i,
  input  logic [CNT_W-1:0]         cmp_i,
  input  tmr_pkg::evt_t            evt_i,
  output logic [tmr_pkg::CTL_W-1:0] ctl_o,
  output logic                     cmp_flag_o,
  output logic                     ovf_flag_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     irq_o
);
  import tmr_pkg::*;

  logic [CTL_W-1:0] ctl_q;
  logic             cf_q, of_q, irq_q;
  logic             cmp_raise, ovf_raise;

  assign cmp_raise = evt_i.cmp && ctl_q[B_CIE];
  assign ovf_raise = evt_i.ovf && ctl_q[B_OIE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      cf_q  <= 1'b0;
      of_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (mode_wr_i) ctl_q <= wdata_i[CTL_W-1:0];
      cf_q  <= (cf_q && !(mode_wr_i && wdata_i[B_CF])) || cmp_raise;
      of_q  <= (of_q && !(mode_wr_i && wdata_i[B_OF])) || ovf_raise;
      irq_q <= cmp_raise || ovf_raise;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_CNT))       rdata_o = DATA_W'(cnt_i);
    else if (addr_i == ADDR_W'(OFS_MODE)) rdata_o = DATA_W'({of_q, cf_q, ctl_q});
    else if (addr_i == ADDR_W'(OFS_CMP))  rdata_o = DATA_W'(cmp_i);
  end

  assign ctl_o      = ctl_q;
  assign cmp_flag_o = cf_q;
  assign ovf_flag_o = of_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DIV_STEP = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import tmr_pkg::*;

  logic [CTL_W-1:0] ctl;
  logic             tick, cnt_wr, cmp_wr, mode_wr;
  logic [CNT_W-1:0] cnt, cmp;
  logic             cmp_flag, ovf_flag;
  evt_t             evt;

  assign cnt_wr  = wr_en_i && (addr_i == ADDR_W'(OFS_CNT));
  assign mode_wr = wr_en_i && (addr_i == ADDR_W'(OFS_MODE));
  assign cmp_wr  = wr_en_i && (addr_i == ADDR_W'(OFS_CMP));

  tmr_prescaler #(.DIV_STEP(DIV_STEP), .SEL_W(2)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (ctl[B_RUN]),
    .sel_i  (ctl[1:0]),
    .tick_o (tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .cnt_wr_i     (cnt_wr),
    .cmp_wr_i     (cmp_wr),
    .wval_i       (wdata_i[CNT_W-1:0]),
    .rst_on_cmp_i (ctl[B_RST] && ctl[B_CIE]),
    .cnt_o        (cnt),
    .cmp_o        (cmp),
    .evt_o        (evt)
  );

  tmr_csr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_wr_i  (mode_wr),
    .wdata_i    (wdata_i),
    .addr_i     (addr_i),
    .cnt_i      (cnt),
    .cmp_i      (cmp),
    .evt_i      (evt),
    .ctl_o      (ctl),
    .cmp_flag_o (cmp_flag),
    .ovf_flag_o (ovf_flag),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [9:0]        ctl_i,
  input logic              cnt_wr_i,
  input logic              mode_wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  cmp_i,
  input logic              cmp_hit_i,
  input logic              ovf_hit_i,
  input logic              cmp_flag_i,
  input logic              irq_i
);
  // R2
  hold_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i[7] && !cnt_wr_i |=> $stable(cnt_i));
  // R8
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_hit_i && !cnt_wr_i |=> cnt_i == '0);
  // R7
  zero_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_i == '0 |-> !cmp_hit_i);
  // R5
  cmp_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_hit_i && ctl_i[8] |=> cmp_flag_i);
  // R10
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i && wdata_i[10] && !cmp_hit_i |=> !cmp_flag_i);
  // R11
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past((cmp_hit_i && ctl_i[8]) || (ovf_hit_i && ctl_i[9])));
endmodule

bind tmr16_top tmr_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctl_i      (ctl),
  .cnt_wr_i   (cnt_wr),
  .mode_wr_i  (mode_wr),
  .wdata_i    (wdata_i),
  .cnt_i      (cnt),
  .cmp_i      (cmp),
  .cmp_hit_i  (evt.cmp),
  .ovf_hit_i  (evt.ovf),
  .cmp_flag_i (cmp_flag),
  .irq_i      (irq_o)
);

// File: tb/tb_tmr16_top.sv
`timescale 1ns/1ps
module tb_tmr16_top;
  localparam logic [3:0] A_CNT = 4'h0, A_MODE = 4'h4, A_CMP = 4'h8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int nchk = 0, nerr = 0, irq_cnt = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  a;
    logic [31:0] e;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  tmr16_top dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: pops expected reads, counts interrupt pulses
  always @(negedge clk) begin
    if (rst_n && irq) irq_cnt++;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      nchk++;
      if (rdata !== it.e) begin
        nerr++;
        $display("FAIL %s: addr %h got %h exp %h", it.tag, it.a, rdata, it.e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic expect_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1 addr = a;
    it.a = a; it.e = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic check_val(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  // exactly n ticks of the bus clock with mode m plus run bit, then mode m
  task automatic run(input logic [31:0] m, input int n);
    @(posedge clk); #1 addr = A_MODE; wdata = m | 32'h80; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
    repeat (n - 1) @(posedge clk);
    #1 wdata = m; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    expect_rd(A_CNT, 0, "R1 count");
    expect_rd(A_MODE, 0, "R1 mode");
    expect_rd(A_CMP, 0, "R1 compare");
    check_val("R1 irq low", int'(irq), 0);
    // R12 unmapped offset
    expect_rd(4'hC, 0, "R12 unmapped");

    // R4 low half load, R2 hold while stopped
    wr(A_CNT, 32'hABCD_0005);
    expect_rd(A_CNT, 5, "R4 count load");
    repeat (5) @(posedge clk);
    expect_rd(A_CNT, 5, "R2 hold");
    run(0, 10);
    expect_rd(A_CNT, 15, "R2 count ticks");

    // R5 compare with interrupt
    wr(A_CNT, 0); wr(A_CMP, 20); irq_cnt = 0;
    run(32'h100, 30);
    expect_rd(A_CNT, 30, "R5 count past match");
    expect_rd(A_MODE, 32'h500, "R5 compare flag");
    check_val("R11 one pulse", irq_cnt, 1);

    // R10 clear only on one
    wr(A_MODE, 32'h100);
    expect_rd(A_MODE, 32'h500, "R10 flag kept");
    wr(A_MODE, 32'h400);
    expect_rd(A_MODE, 0, "R10 flag cleared");

    // R6 reset on compare with enable
    wr(A_CNT, 0); wr(A_CMP, 10); irq_cnt = 0;
    run(32'h140, 15);
    expect_rd(A_CNT, 5, "R6 reset on match");
    expect_rd(A_MODE, 32'h540, "R6 flag");
    check_val("R6 irq", irq_cnt, 1);
    wr(A_MODE, 32'h400);

    // R6 reset bit alone has no effect
    wr(A_CNT, 0); wr(A_CMP, 10); irq_cnt = 0;
    run(32'h040, 15);
    expect_rd(A_CNT, 15, "R6 no reset without enable");
    expect_rd(A_MODE, 32'h040, "R6 no flag");
    check_val("R6 no irq", irq_cnt, 0);

    // R7 zero compare never matches
    wr(A_CNT, 0); wr(A_CMP, 0); irq_cnt = 0;
    run(32'h100, 8);
    expect_rd(A_MODE, 32'h100, "R7 zero compare");
    check_val("R7 no irq", irq_cnt, 0);

    // R8 overflow with and without enable
    wr(A_CNT, 32'hFFFA); irq_cnt = 0;
    run(32'h200, 10);
    expect_rd(A_CNT, 4, "R8 wrap");
    expect_rd(A_MODE, 32'hA00, "R8 overflow flag");
    check_val("R8 irq", irq_cnt, 1);
    wr(A_MODE, 32'h800);
    expect_rd(A_MODE, 0, "R10 overflow flag cleared");
    wr(A_CNT, 32'hFFFA); irq_cnt = 0;
    run(0, 10);
    expect_rd(A_CNT, 4, "R8 wrap disabled");
    expect_rd(A_MODE, 0, "R8 no flag");
    check_val("R8 no irq", irq_cnt, 0);

    // R9 late compare deferred (below and equal)
    wr(A_CNT, 32'h100); wr(A_CMP, 32'h80); irq_cnt = 0;
    expect_rd(A_CMP, 32'h80, "R12 compare read");
    run(32'h100, 20);
    expect_rd(A_CNT, 32'h114, "R9 count");
    expect_rd(A_MODE, 32'h100, "R9 below deferred");
    wr(A_CNT, 32'h50); wr(A_CMP, 32'h50);
    run(32'h100, 5);
    expect_rd(A_MODE, 32'h100, "R9 equal deferred");
    check_val("R9 no irq", irq_cnt, 0);

    // R9 re-armed after wrap
    wr(A_CNT, 32'hFFFE); wr(A_CMP, 32'h80); irq_cnt = 0;
    run(32'h100, 140);
    expect_rd(A_CNT, 32'h8A, "R9 count after wrap");
    expect_rd(A_MODE, 32'h500, "R9 match after wrap");
    check_val("R9 irq", irq_cnt, 1);
    wr(A_MODE, 32'h400);

    // R4 count write re-arms
    wr(A_CNT, 32'h200); wr(A_CMP, 32'h80); wr(A_CNT, 32'h300); irq_cnt = 0;
    run(32'h100, 1);
    expect_rd(A_CNT, 32'h301, "R4 count");
    expect_rd(A_MODE, 32'h500, "R4 rearmed match");
    wr(A_MODE, 32'h400);

    // R11 coincident compare and overflow
    wr(A_CNT, 0); wr(A_CMP, 32'h10); wr(A_CNT, 32'hFFFF); irq_cnt = 0;
    run(32'h300, 1);
    expect_rd(A_CNT, 0, "R11 count");
    expect_rd(A_MODE, 32'hF00, "R11 both flags");
    check_val("R11 single pulse", irq_cnt, 1);
    wr(A_MODE, 32'hC00);
    expect_rd(A_MODE, 0, "R10 both cleared");

    // R3 prescaler
    wr(A_CNT, 0); wr(A_CMP, 0);
    run(32'h001, 32);
    expect_rd(A_CNT, 2, "R3 divide 16");
    run(32'h002, 600);
    expect_rd(A_CNT, 4, "R3 divide 256");
    expect_rd(A_MODE, 32'h002, "R3 mode");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule